// File: doc/BRIEF.md
# Processor Input-Pin Interrupt Front End

This block sits between seven external processor control pins and the pending-interrupt register of a core. Each pin change arrives as a one-cycle strobe that carries a pin index and a level. The block keeps the last level it accepted for every pin. It drops any event whose level matches that stored value, so repeated or spurious notifications never reach the core.

An accepted change is handled by the rule of its pin. Level-following pins set or clear a pending bit. The machine-check pin latches a pending bit on a falling edge only. The checkstop pin drives a halt output. Hard reset and time-base enable only update their stored state. The core clears pending bits it has taken through an acknowledge mask. When an acknowledge and a pin event target the same bit in one cycle, the pin event wins.

All outputs are registered. An event applied at one rising clock edge is visible on the outputs after that edge.

Top module: `pin_irq_frontend`

## Requirements
- R1: While reset is asserted (`rst_ni` low), the pin-state vector, the pending vector and halt all read zero.
- R2: An event with `evt_valid_i` low, or one whose level equals the stored state bit of its pin, changes neither the pin state, the pending vector nor halt.
- R3: An event whose pin index is 7 (outside 0..6) is ignored completely, and no state bit is written.
- R4: Pin 5 (external interrupt) is level sensitive and active high. Pending bit 1 follows its new level.
- R5: Pin 6 (thermal) is level sensitive and active high. Pending bit 6 follows its new level.
- R6: Pin 4 (machine check) sets pending bit 2 on a change from 1 to 0. A change from 0 to 1 leaves bit 2 untouched.
- R7: On pin 2 (checkstop), a new level of 1 asserts `halt_o` and a new level of 0 deasserts it. No other pin affects halt.
- R8: Pin 1 (soft reset) sets or clears pending bit 0 to follow its level.
- R9: Changes on pin 0 (hard reset) and pin 3 (time-base enable) alter no pending bit, but their state bits are updated.
- R10: After an accepted change, state bit `pin_state_o[idx]` holds the new level. Any nonzero `evt_level_i` counts as level 1.
- R11: A 1 in `ack_i` clears that pending bit at the next edge. A set caused by a pin event in the same cycle takes priority over the clear.
- R12: Pending bits 3, 4, 5 and 7 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | Pin-change event strobe |
| evt_pin_i | input | IDX_W (3) | Pin index of the event |
| evt_level_i | input | LEVEL_W (2) | New pin level; nonzero means 1 |
| ack_i | input | PEND_W (8) | Mask of pending bits to clear |
| pend_o | output | PEND_W (8) | Pending exception vector |
| halt_o | output | 1 | Halt request to the core |
| pin_state_o | output | NUM_PINS (7) | Last accepted level of each pin |

## Verification
The bench builds the block with its defaults: seven pins, which gives a 3-bit index, a 2-bit level and an 8-bit pending vector. Because the index is 3 bits wide, code 7 can be driven to exercise the out-of-range rule. Because the level is 2 bits wide, values 2 and 3 show that any nonzero level is read as 1. The 8-bit acknowledge mask can hit the tied-zero bits, and it can hit a bit in the same cycle that a pin event sets it, which exercises the set-over-clear priority.

// File: rtl/pinfe_pkg.sv
package pinfe_pkg;
  typedef enum logic [2:0] {
    PIN_HRST  = 3'd0,
    PIN_SRST  = 3'd1,
    PIN_CSTOP = 3'd2,
    PIN_TBEN  = 3'd3,
    PIN_MCHK  = 3'd4,
    PIN_EXT   = 3'd5,
    PIN_THERM = 3'd6
  } pin_e;

  localparam int PB_RST   = 0;
  localparam int PB_EXT   = 1;
  localparam int PB_MCHK  = 2;
  localparam int PB_THERM = 6;
endpackage

// File: rtl/pinfe_filter.sv
module pinfe_filter #(
  parameter int NUM_PINS = 7,
  parameter int IDX_W    = 3,
  parameter int LEVEL_W  = 2
) (
  input  logic                evt_valid_i,
  input  logic [IDX_W-1:0]    evt_pin_i,
  input  logic [LEVEL_W-1:0]  evt_level_i,
  input  logic [NUM_PINS-1:0] state_i,
  output logic [NUM_PINS-1:0] sel_o,
  output logic                lvl_o,
  output logic                hit_o
);
  logic cur;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_sel
    assign sel_o[i] = evt_valid_i && (evt_pin_i == IDX_W'(i));
  end

  assign lvl_o = |evt_level_i;
  assign cur   = |(state_i & sel_o);
  // out-of-range index leaves sel_o all zero, so no hit
  assign hit_o = (|sel_o) && (cur != lvl_o);
endmodule

// File: rtl/pinfe_action.sv
module pinfe_action
  import pinfe_pkg::*;
#(
  parameter int NUM_PINS = 7,
  parameter int PEND_W   = 8
) (
  input  logic [NUM_PINS-1:0] sel_i,
  input  logic                lvl_i,
  input  logic                hit_i,
  output logic [PEND_W-1:0]   set_o,
  output logic [PEND_W-1:0]   clr_o,
  output logic                halt_we_o
);
  logic ext_chg, thm_chg, srst_chg, mchk_chg;

  assign ext_chg  = hit_i && sel_i[PIN_EXT];
  assign thm_chg  = hit_i && sel_i[PIN_THERM];
  assign srst_chg = hit_i && sel_i[PIN_SRST];
  assign mchk_chg = hit_i && sel_i[PIN_MCHK];

  always_comb begin
    set_o = '0;
    clr_o = '0;
    set_o[PB_EXT]   = ext_chg && lvl_i;
    clr_o[PB_EXT]   = ext_chg && !lvl_i;
    set_o[PB_THERM] = thm_chg && lvl_i;
    clr_o[PB_THERM] = thm_chg && !lvl_i;
    set_o[PB_RST]   = srst_chg && lvl_i;
    clr_o[PB_RST]   = srst_chg && !lvl_i;
    // falling edge only; rising edge leaves the bit alone
    set_o[PB_MCHK]  = mchk_chg && !lvl_i;
  end

  assign halt_we_o = hit_i && sel_i[PIN_CSTOP];
endmodule

// File: rtl/pinfe_pend.sv
module pinfe_pend #(
  parameter int PEND_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PEND_W-1:0] set_i,
  input  logic [PEND_W-1:0] clr_i,
  input  logic [PEND_W-1:0] ack_i,
  output logic [PEND_W-1:0] pend_o
);
  logic [PEND_W-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~(clr_i | ack_i)) | set_i;
  end

  assign pend_o = pend_q;

  p_set_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((pend_o & $past(set_i)) == $past(set_i)));

  p_ack_clears_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(ack_i & ~set_i)) |=> ((pend_o & $past(ack_i & ~set_i)) == '0));
endmodule

// File: rtl/pin_irq_frontend.sv
module pin_irq_frontend
  import pinfe_pkg::*;
#(
  parameter int NUM_PINS = 7,
  parameter int PEND_W   = 8,
  parameter int LEVEL_W  = 2,
  parameter int IDX_W    = $clog2(NUM_PINS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                evt_valid_i,
  input  logic [IDX_W-1:0]    evt_pin_i,
  input  logic [LEVEL_W-1:0]  evt_level_i,
  input  logic [PEND_W-1:0]   ack_i,
  output logic [PEND_W-1:0]   pend_o,
  output logic                halt_o,
  output logic [NUM_PINS-1:0] pin_state_o
);
  logic [NUM_PINS-1:0] state_q;
  logic [NUM_PINS-1:0] sel;
  logic                lvl, hit, halt_we, halt_q;
  logic [PEND_W-1:0]   set_v, clr_v;

  pinfe_filter #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W), .LEVEL_W(LEVEL_W)) i_filter (
    .evt_valid_i (evt_valid_i),
    .evt_pin_i   (evt_pin_i),
    .evt_level_i (evt_level_i),
    .state_i     (state_q),
    .sel_o       (sel),
    .lvl_o       (lvl),
    .hit_o       (hit)
  );

  pinfe_action #(.NUM_PINS(NUM_PINS), .PEND_W(PEND_W)) i_action (
    .sel_i     (sel),
    .lvl_i     (lvl),
    .hit_i     (hit),
    .set_o     (set_v),
    .clr_o     (clr_v),
    .halt_we_o (halt_we)
  );

  pinfe_pend #(.PEND_W(PEND_W)) i_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_v),
    .clr_i  (clr_v),
    .ack_i  (ack_i),
    .pend_o (pend_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      halt_q  <= 1'b0;
    end else begin
      if (hit)     state_q <= (state_q & ~sel) | (lvl ? sel : '0);
      if (halt_we) halt_q  <= lvl;
    end
  end

  assign halt_o      = halt_q;
  assign pin_state_o = state_q;

  p_same_level_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && evt_pin_i < IDX_W'(NUM_PINS) && ((pin_state_o >> evt_pin_i) & 1) == (|evt_level_i))
      |=> $stable(pin_state_o) && $stable(halt_o));

  p_out_of_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && evt_pin_i >= IDX_W'(NUM_PINS)) |=> $stable(pin_state_o) && $stable(halt_o));

  p_halt_source_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(evt_valid_i && evt_pin_i == IDX_W'(PIN_CSTOP)) |=> $stable(halt_o));

  p_mchk_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && evt_pin_i == IDX_W'(PIN_MCHK) && pin_state_o[PIN_MCHK] && !(|evt_level_i))
      |=> pend_o[PB_MCHK]);
endmodule

// File: tb/test_pin_irq_frontend.sv
module test_pin_irq_frontend;
  localparam int NUM_PINS = 7;
  localparam int PEND_W   = 8;
  localparam int LEVEL_W  = 2;
  localparam int IDX_W    = 3;
  localparam int NV       = 18;

  // {req[3:0], pin[2:0], lvl[1:0], ack[7:0], exp_pend[7:0], exp_halt, exp_state[6:0]}
  localparam logic [32:0] VEC [NV] = '{
    {4'd4,  3'd5, 2'd1, 8'h00, 8'h02, 1'b0, 7'h20},  // R4 ext rise
    {4'd10, 3'd5, 2'd2, 8'h00, 8'h02, 1'b0, 7'h20},  // R10 nonzero same level, R2
    {4'd5,  3'd6, 2'd1, 8'h00, 8'h42, 1'b0, 7'h60},  // R5 thermal rise
    {4'd6,  3'd4, 2'd1, 8'h00, 8'h42, 1'b0, 7'h70},  // R6 mchk rise: no bit
    {4'd6,  3'd4, 2'd0, 8'h00, 8'h46, 1'b0, 7'h60},  // R6 mchk fall sets bit 2
    {4'd7,  3'd2, 2'd1, 8'h00, 8'h46, 1'b1, 7'h64},  // R7 halt on
    {4'd8,  3'd1, 2'd3, 8'h00, 8'h47, 1'b1, 7'h66},  // R8 soft reset on
    {4'd9,  3'd0, 2'd1, 8'h00, 8'h47, 1'b1, 7'h67},  // R9 hard reset
    {4'd9,  3'd3, 2'd1, 8'h00, 8'h47, 1'b1, 7'h6F},  // R9 time base
    {4'd3,  3'd7, 2'd1, 8'h00, 8'h47, 1'b1, 7'h6F},  // R3 bad index
    {4'd4,  3'd5, 2'd0, 8'h00, 8'h45, 1'b1, 7'h4F},  // R4 ext fall
    {4'd5,  3'd6, 2'd0, 8'h00, 8'h05, 1'b1, 7'h0F},  // R5 thermal fall
    {4'd7,  3'd2, 2'd0, 8'h00, 8'h05, 1'b0, 7'h0B},  // R7 halt off
    {4'd8,  3'd1, 2'd0, 8'h00, 8'h04, 1'b0, 7'h09},  // R8 soft reset off
    {4'd11, 3'd4, 2'd0, 8'h04, 8'h00, 1'b0, 7'h09},  // R11 ack clears mchk
    {4'd11, 3'd1, 2'd1, 8'h01, 8'h01, 1'b0, 7'h0B},  // R11 set wins over ack
    {4'd9,  3'd0, 2'd0, 8'hFF, 8'h00, 1'b0, 7'h0A},  // R9 hard reset off, full ack
    {4'd9,  3'd3, 2'd0, 8'h00, 8'h00, 1'b0, 7'h02}   // R9 time base off
  };

  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic                evt_valid_i = 1'b0;
  logic [IDX_W-1:0]    evt_pin_i = '0;
  logic [LEVEL_W-1:0]  evt_level_i = '0;
  logic [PEND_W-1:0]   ack_i = '0;
  logic [PEND_W-1:0]   pend_o;
  logic                halt_o;
  logic [NUM_PINS-1:0] pin_state_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  pin_irq_frontend #(.NUM_PINS(NUM_PINS), .PEND_W(PEND_W), .LEVEL_W(LEVEL_W)) i_pin_irq_frontend (
    .clk_i, .rst_ni, .evt_valid_i, .evt_pin_i, .evt_level_i, .ack_i,
    .pend_o, .halt_o, .pin_state_o
  );

  task automatic check(input int req, input logic [7:0] ep, input logic eh, input logic [6:0] es);
    checks++;
    if (pend_o !== ep || halt_o !== eh || pin_state_o !== es) begin
      errors++;
      $display("FAIL R%0d: pend=%h halt=%b state=%h expected pend=%h halt=%b state=%h",
               req, pend_o, halt_o, pin_state_o, ep, eh, es);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, return at the next falling edge
  task automatic apply(input logic v, input logic [2:0] p, input logic [1:0] l, input logic [7:0] a);
    evt_valid_i = v; evt_pin_i = p; evt_level_i = l; ack_i = a;
    @(posedge clk_i);
    @(negedge clk_i);
    evt_valid_i = 1'b0; ack_i = '0;
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(1, 8'h00, 1'b0, 7'h00);  // R1 reset state
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      apply(1'b1, VEC[i][28:26], VEC[i][25:24], VEC[i][23:16]);
      check(int'(VEC[i][32:29]), VEC[i][15:8], VEC[i][7], VEC[i][6:0]);
    end

    // R2: strobe low with a differing level does nothing
    apply(1'b0, 3'd5, 2'd1, 8'h00);
    check(2, 8'h00, 1'b0, 7'h02);
    // R2: same level on checkstop keeps halt low
    apply(1'b1, 3'd2, 2'd0, 8'h00);
    check(2, 8'h00, 1'b0, 7'h02);

    // R12: raise every source, ack all bits, unused bits stay zero
    apply(1'b1, 3'd5, 2'd1, 8'h00);
    apply(1'b1, 3'd6, 2'd1, 8'h00);
    apply(1'b1, 3'd1, 2'd0, 8'h00);
    apply(1'b1, 3'd4, 2'd1, 8'hB8);
    check(12, 8'h42, 1'b0, 7'h70);
    apply(1'b1, 3'd4, 2'd0, 8'h00);
    check(6, 8'h46, 1'b0, 7'h60);
    // R11: ack on ext while thermal falls
    apply(1'b1, 3'd6, 2'd0, 8'h02);
    check(11, 8'h04, 1'b0, 7'h20);

    // R1: reset mid-run clears everything
    apply(1'b1, 3'd2, 2'd1, 8'h00);
    check(7, 8'h04, 1'b1, 7'h24);
    rst_ni = 1'b0;
    #3;
    check(1, 8'h00, 1'b0, 7'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R10: after reset a level-1 event is a real change again
    apply(1'b1, 3'd5, 2'd3, 8'h00);
    check(10, 8'h02, 1'b0, 7'h20);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule